// File: doc/BRIEF.md
# Prescaled 16-bit Down-Counting Timer

This block is a small register-mapped timer. A 16-bit counter counts down from a value that software writes. A prescaler sits in front of the counter and divides the reference clock by 1, 16 or 256. Software writes a reload value and then writes a control byte. The control byte sets the enable, picks between free-running and periodic counting, and picks the prescale ratio. The counter steps down by one on each prescaled tick.

When a tick brings the count to zero, a sticky flag is set. The interrupt output is this flag gated by the enable bit. Software clears the flag by writing any value to a dedicated clear offset. The current count can be read at any time. The block sits behind a simple single-cycle write strobe with a combinational read port. The bus fabric and the interrupt controller are outside it.

Top module: `pdt_timer`

## Requirements
- R1: Reading offset 0x4 returns the current count in bits 15:0 with zeros above. The count decreases by exactly one on each prescaled tick. Writes to 0x4, and reads or writes of any unmapped offset, have no effect and read as zero.
- R2: A write to offset 0x0 stores bits 15:0 as the reload value, which reads back at 0x0. The same write loads the count at once and restarts the prescaler from zero. This happens whether or not the timer is enabled, and it wins over a tick in the same cycle.
- R3: With control bit 6 clear (free-running), a tick at count 0 moves the count to 0xFFFF.
- R4: With control bit 6 set (periodic), a tick at count 0 moves the count to the stored reload value.
- R5: Control bits 3:2 choose the tick rate. 2'b00 ticks on every enabled cycle. 2'b01 ticks on every 16th enabled cycle. 2'b10 ticks on every 256th enabled cycle. 2'b11 behaves as 2'b00.
- R6: While control bit 7 is clear, the count and the prescaler hold their values. Offset 0x8 reads back control bits 7, 6, 3 and 2, with every other bit zero.
- R7: The flag is set by any tick whose resulting count is zero. It stays set until a write to offset 0xC. A set and a clear in the same cycle leave the flag set.
- R8: The interrupt output equals the flag ANDed with control bit 7.
- R9: After a synchronous reset, the reload value, count, control and flag are all zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 4 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current offset (combinational) |
| irq | output | 1 | Zero-reach interrupt, flag gated by enable |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as a tick that sets the flag. The bench reaches it by running periodic mode at the undivided rate with a reload of 1, so the count returns to zero every other cycle, and then issuing clear writes on back-to-back cycles. The divide-by-256 boundary is also exercised, along with load writes that restart the prescaler partway through a prescale period. A behavioural model is compared with the read port and the interrupt on every clock.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    localparam int CNT_W       = 16;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int DIV_LO_LOG2 = 4;
    localparam int DIV_HI_LOG2 = 8;
    localparam int CTL_W       = 8;

    // register offsets; the control bit positions are fixed by the software view
    localparam logic [ADDR_W-1:0] OFF_LOAD  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_VALUE = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_CLEAR = 4'hC;

    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_MODE_BIT = 6;
    localparam int CTL_PSC_LSB  = 2;

    typedef enum logic [1:0] {
        PSC_DIV1   = 2'b00,
        PSC_DIVLO  = 2'b01,
        PSC_DIVHI  = 2'b10,
        PSC_RSVD   = 2'b11
    } psc_e;

    typedef struct packed {
        logic en;
        logic periodic;
        psc_e psc;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [CTL_W-1:0] b);
        ctrl_t c;
        c.en       = b[CTL_EN_BIT];
        c.periodic = b[CTL_MODE_BIT];
        c.psc      = psc_e'(b[CTL_PSC_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTL_W-1:0] b;
        b                    = '0;
        b[CTL_EN_BIT]        = c.en;
        b[CTL_MODE_BIT]      = c.periodic;
        b[CTL_PSC_LSB +: 2]  = c.psc;
        return b;
    endfunction

endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler
    import pdt_pkg::*;
#(
    parameter int LO_LOG2 = DIV_LO_LOG2,
    parameter int HI_LOG2 = DIV_HI_LOG2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  psc_e psc,
    output logic tick
);
    localparam int PRE_W = HI_LOG2;

    logic [PRE_W-1:0] pre_q;
    logic             wrap_lo;
    logic             wrap_hi;
    logic             sel_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign wrap_lo = &pre_q[LO_LOG2-1:0];
    assign wrap_hi = &pre_q[HI_LOG2-1:0];

    always_comb begin
        unique case (psc)
            PSC_DIVLO: sel_hit = wrap_lo;
            PSC_DIVHI: sel_hit = wrap_hi;
            default:   sel_hit = 1'b1;
        endcase
    end

    assign tick = run && !restart && sel_hit;

endmodule

// File: rtl/pdt_counter.sv
module pdt_counter
    import pdt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_now,
    input  logic [W-1:0] load_data,
    input  logic [W-1:0] reload_val,
    input  logic         periodic,
    input  logic         tick,
    input  logic         clr_flag,
    output logic [W-1:0] count,
    output logic         flag
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_step;
    logic         flag_q;
    logic         hit_zero;

    always_comb begin
        if (cnt_q == '0) begin
            cnt_step = periodic ? reload_val : {W{1'b1}};
        end else begin
            cnt_step = cnt_q - 1'b1;
        end
    end

    assign hit_zero = tick && !load_now && (cnt_step == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_now) begin
            cnt_q <= load_data;
        end else if (tick) begin
            cnt_q <= cnt_step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (hit_zero) begin
            flag_q <= 1'b1;
        end else if (clr_flag) begin
            flag_q <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign flag  = flag_q;

endmodule

// File: rtl/pdt_regs.sv
module pdt_regs
    import pdt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] count,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] reload_val,
    output ctrl_t         ctrl,
    output logic          load_wr,
    output logic          clear_wr
);
    logic [CW-1:0] load_q;
    ctrl_t         ctrl_q;
    logic          ctrl_wr;

    assign load_wr  = wr_en && (addr == OFF_LOAD);
    assign ctrl_wr  = wr_en && (addr == OFF_CTRL);
    assign clear_wr = wr_en && (addr == OFF_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
        end else if (load_wr) begin
            load_q <= wdata[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_unpack(wdata[CTL_W-1:0]);
        end
    end

    always_comb begin
        unique case (addr)
            OFF_LOAD:  rdata = DW'(load_q);
            OFF_VALUE: rdata = DW'(count);
            OFF_CTRL:  rdata = DW'(ctrl_pack(ctrl_q));
            default:   rdata = '0;
        endcase
    end

    assign reload_val = load_q;
    assign ctrl       = ctrl_q;

endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
    import pdt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    ctrl_t         ctrl;
    logic [CW-1:0] reload_val;
    logic [CW-1:0] count;
    logic          load_wr;
    logic          clear_wr;
    logic          tick;
    logic          flag;
    logic          en_w;
    logic          periodic_w;

    assign en_w       = ctrl.en;
    assign periodic_w = ctrl.periodic;

    pdt_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .count      (count),
        .rdata      (rdata),
        .reload_val (reload_val),
        .ctrl       (ctrl),
        .load_wr    (load_wr),
        .clear_wr   (clear_wr)
    );

    pdt_prescaler #(.LO_LOG2(DIV_LO_LOG2), .HI_LOG2(DIV_HI_LOG2)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (en_w),
        .restart (load_wr),
        .psc     (ctrl.psc),
        .tick    (tick)
    );

    pdt_counter #(.W(CW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_now   (load_wr),
        .load_data  (wdata[CW-1:0]),
        .reload_val (reload_val),
        .periodic   (periodic_w),
        .tick       (tick),
        .clr_flag   (clear_wr),
        .count      (count),
        .flag       (flag)
    );

    assign irq = flag && en_w;

endmodule

// File: rtl/pdt_timer_chk.sv
module pdt_timer_chk #(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] wdata,
    input logic          ld_wr,
    input logic          clr_wr,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] load_val,
    input logic          en,
    input logic          periodic,
    input logic          flag,
    input logic          irq
);
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        ld_wr |=> cnt == $past(wdata[CW-1:0])); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!ld_wr && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - CW'(1))); // R1
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!ld_wr && cnt == '0 && !periodic) |=> (cnt == '0 || &cnt)); // R3
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!ld_wr && cnt == '0 && periodic) |=> (cnt == '0 || cnt == $past(load_val))); // R4
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !ld_wr) |=> $stable(cnt)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_wr) |=> flag); // R7
    AST_ZERO_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!ld_wr && cnt == CW'(1)) |=> (cnt == CW'(1) || flag)); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !en |-> !irq); // R8
endmodule

bind pdt_timer pdt_timer_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wdata    (wdata),
    .ld_wr    (load_wr),
    .clr_wr   (clear_wr),
    .cnt      (count),
    .load_val (reload_val),
    .en       (en_w),
    .periodic (periodic_w),
    .flag     (flag),
    .irq      (irq)
);

// File: tb/pdt_timer_bench.sv
module pdt_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h4;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    bit running = 0;
    bit done = 0;
    string tag = "R9";

    // behavioural reference state
    int m_load = 0, m_cnt = 0, m_ctrl = 0, m_pre = 0;
    bit m_flag = 0;

    always #5 clk = ~clk;

    pdt_timer u_pdt_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic int model_read(input logic [3:0] a);
        case (a)
            4'h0:    return m_load;
            4'h4:    return m_cnt;
            4'h8:    return m_ctrl & 8'hCC;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_load = 0; m_cnt = 0; m_ctrl = 0; m_pre = 0; m_flag = 0;
        end else begin
            bit en, set_now, tk;
            int div, nxt;
            en = m_ctrl[7];
            set_now = 0;
            if (wr_en && addr == 4'h0) begin
                m_load = wdata & 32'hFFFF;
                m_cnt = m_load;
                m_pre = 0;
            end else if (en) begin
                case ((m_ctrl >> 2) & 3)
                    1: div = 16;
                    2: div = 256;
                    default: div = 1;
                endcase
                tk = (m_pre % div) == (div - 1);
                m_pre = (m_pre + 1) % 256;
                if (tk) begin
                    if (m_cnt == 0) nxt = m_ctrl[6] ? m_load : 65535;
                    else nxt = m_cnt - 1;
                    m_cnt = nxt;
                    if (nxt == 0) set_now = 1;
                end
            end
            if (set_now) m_flag = 1;
            else if (wr_en && addr == 4'hC) m_flag = 0;
            if (wr_en && addr == 4'h8) m_ctrl = wdata & 8'hFF;
        end
    end

    always @(negedge clk) begin
        if (running) begin
            int exp_rd;
            bit exp_irq;
            exp_rd = model_read(addr);
            exp_irq = m_flag && m_ctrl[7];
            vectors++;
            if (rdata !== exp_rd) begin
                miscompares++;
                $display("FAIL %s rdata@%h actual %h expected %h", tag, addr, rdata, exp_rd);
            end else if (irq !== exp_irq) begin
                miscompares++;
                $display("FAIL %s irq actual %b expected %b (R8)", tag, irq, exp_irq);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 1'b0; addr = 4'h4;
    endtask

    task automatic peek(input logic [3:0] a);
        @(posedge clk); #2;
        addr = a;
        @(posedge clk); #2;
        addr = 4'h4;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #2;
        running = 1;
        tag = "R9";
        idle(3);
        #2 rst = 1'b0;
        peek(4'h0); peek(4'h8); peek(4'h4);

        tag = "R3";
        wr(4'h0, 32'h0000_0005);
        wr(4'h8, 32'h0000_0080);
        idle(12);

        tag = "R7";
        wr(4'hC, 32'h1234_5678);
        idle(4);

        tag = "R4";
        wr(4'h8, 32'h0000_00C0);
        wr(4'h0, 32'h0000_0003);
        idle(14);
        peek(4'h0);

        tag = "R5";
        wr(4'h8, 32'h0000_00C4);
        wr(4'h0, 32'h0000_0004);
        idle(90);
        wr(4'h8, 32'h0000_0088);
        wr(4'h0, 32'h0000_0002);
        idle(800);
        wr(4'h8, 32'h0000_00CC);
        wr(4'h0, 32'h0000_0003);
        idle(12);

        tag = "R2";
        wr(4'h8, 32'h0000_00C4);
        idle(7);
        wr(4'h0, 32'h0000_0009);
        idle(40);

        tag = "R6";
        wr(4'h8, 32'h0000_004C);
        idle(20);
        wr(4'h0, 32'h0000_0006);
        idle(10);
        wr(4'h8, 32'h0000_00FF);
        peek(4'h8);
        idle(20);

        tag = "R8";
        wr(4'h8, 32'h0000_0040);
        idle(5);
        wr(4'h8, 32'h0000_00C0);
        idle(5);

        tag = "R1";
        wr(4'h4, 32'h0000_AAAA);
        wr(4'h2, 32'h0000_5555);
        peek(4'h2); peek(4'hE);
        wr(4'h0, 32'hFFFF_0040);
        wr(4'h8, 32'h0000_0080);
        idle(30);

        tag = "R7";
        wr(4'h8, 32'h0000_00C0);
        wr(4'h0, 32'h0000_0001);
        repeat (6) begin
            @(posedge clk); #2;
            wr_en = 1'b1; addr = 4'hC; wdata = 32'h0;
        end
        @(posedge clk); #2;
        wr_en = 1'b0; addr = 4'h4;
        idle(4);

        tag = "R9";
        @(posedge clk); #2 rst = 1'b1;
        idle(2);
        #2 rst = 1'b0;
        peek(4'h0); peek(4'h8);
        idle(3);

        running = 0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule